// File: doc/BRIEF.md
# SDR SDRAM Burst and Read-Latency Data Pipeline

This block is the data side of a single-data-rate SDRAM controller. Whenever the command side puts a READ or WRITE on the memory bus it also pulses a command event here, with the starting column, the burst-length code and the read latency. From that event the block produces one column per clock for the whole burst. On write beats it turns the bus drivers on and converts the caller's byte enables into per-byte mask bits. For read beats it delays a valid flag by the programmed latency, so the caller knows which returning bus words are real read data.

A burst can be cut short. A new READ or WRITE may be accepted on any cycle and replaces the running burst. A stop request, meaning a burst terminate or a precharge issued by the command side, ends it with no replacement. A WRITE that arrives while read data is still travelling back from the memory discards that read data. This avoids a bus collision and matches the memory's behaviour when a write interrupts a read. Between bursts the mask bits stay high, so no stray byte is written.

Top module: `sdr_burst_datapath`

## Requirements
- R1: The burst-length code sets the number of beats. Code 0 gives 1 beat, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Any code with bit 2 set selects a full-page burst, which runs until it is stopped or replaced. `col_en` is high for exactly that many consecutive cycles, starting with the command cycle.
- R2: For a burst of length L starting at column S, beat k carries column (S with its low log2(L) bits cleared) OR ((S+k) mod L). The order is sequential and wraps inside the aligned block of L columns.
- R3: A full-page burst counts up through all 2^COL_W columns and wraps from the last column to column 0.
- R4: Each read beat issued in cycle c raises `rd_valid` in cycle c+CL, with `rd_data` equal to `dq_in` in that cycle. CL is `cas_lat` and may be 1, 2 or 3.
- R5: A stop request with no command in the same cycle produces no beat in that cycle or any later cycle. Read data of earlier beats is still delivered. The write word of the stop cycle is not driven, and its mask bits stay high.
- R6: A new command on any cycle ends the running burst. The command cycle is beat 0 of the new burst. Read data of the earlier burst's beats is still delivered.
- R7: On a write beat, `dq_oe` is 1, `dq_out` equals `wr_data`, and `dqm[b]` is the inverse of `wr_be[b]` for each byte b.
- R8: A write beat clears all read data still in flight. `rd_valid` is low in that cycle, and it stays low later for every read beat issued before it.
- R9: `dqm` is all zeros during read beats and while read data is in flight. It is all ones when there is no beat and no read data is pending.
- R10: After reset, `col_en`, `dq_oe` and `rd_valid` are 0 and `dqm` is all ones.
- R11: When a command and a stop request occur in the same cycle, the command takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A READ or WRITE is on the memory bus this cycle |
| cmd_write | input | 1 | 1 = WRITE, 0 = READ |
| cmd_col | input | COL_W | Starting column |
| cmd_stop | input | 1 | Burst terminate or precharge this cycle |
| bl_code | input | 3 | Burst-length code (R1) |
| cas_lat | input | $clog2(MAX_CL+1) | Read latency in cycles |
| wr_data | input | DATA_W | Write word for the current write beat |
| wr_be | input | DATA_W/8 | Byte enables for the current write beat |
| dq_in | input | DATA_W | Data bus as seen from the memory |
| col_en | output | 1 | A burst beat is on the bus this cycle |
| col_out | output | COL_W | Column of the current beat |
| dq_out | output | DATA_W | Data driven onto the bus |
| dq_oe | output | 1 | Bus driver enable (write beat) |
| dqm | output | DATA_W/8 | Per-byte mask bits |
| rd_valid | output | 1 | `rd_data` holds a wanted read word |
| rd_data | output | DATA_W | Read word |

## Verification
The bench targets these corner cases, each with the failure a wrong design would show:
- Column wrap inside 4- and 8-beat blocks and across the end of the page. A design that adds without masking would step into the neighbouring block or past column 511.
- Read latency at each CL value. An off-by-one tap shows up as a shifted cycle stamp on every returned word.
- Truncation by a stop, by a second read, and by a write that overlaps in-flight read data. A design that does not discard that data would raise `rd_valid` while it drives the bus.
- A partially masked write and the idle mask level. These show whether disabled bytes could be corrupted in a behavioural memory model.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;
   localparam int BL_FIELD_W = 3;
   localparam int MAX_FIXED_BEATS = 8;
   localparam int LEFT_W = $clog2(MAX_FIXED_BEATS) + 1;

   typedef enum logic [BL_FIELD_W-1:0] {
      BURST_1    = 3'd0,
      BURST_2    = 3'd1,
      BURST_4    = 3'd2,
      BURST_8    = 3'd3,
      BURST_PAGE = 3'd7
   } burst_code_e;
endpackage

// File: rtl/sdrb_colgen.sv
module sdrb_colgen
   import sdrb_pkg::*;
#(
   parameter int COL_W = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_write,
   input  logic [COL_W-1:0]      cmd_col,
   input  logic                  stop,
   input  logic [BL_FIELD_W-1:0] bl_code,
   output logic                  beat,
   output logic                  beat_wr,
   output logic [COL_W-1:0]      beat_col
);
   logic                act_q, wr_q, page_q;
   logic [COL_W-1:0]    start_q, mask_q, k_q;
   logic [LEFT_W-1:0]   left_q;

   logic                cmd_page;
   logic [1:0]          cmd_lg;
   logic [COL_W-1:0]    cmd_mask;
   logic [LEFT_W-1:0]   cmd_left;

   always_comb begin
      cmd_page = bl_code[2];
      cmd_lg   = bl_code[1:0];
      cmd_mask = cmd_page ? '1 : ((COL_W'(1) << cmd_lg) - COL_W'(1));
      cmd_left = (LEFT_W'(1) << cmd_lg) - LEFT_W'(1);
   end

   always_comb begin
      beat     = cmd_valid | (act_q & ~stop);
      beat_wr  = cmd_valid ? cmd_write : wr_q;
      beat_col = cmd_valid ? cmd_col
                           : ((start_q & ~mask_q) | ((start_q + k_q) & mask_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wr_q    <= 1'b0;
         page_q  <= 1'b0;
         start_q <= '0;
         mask_q  <= '0;
         k_q     <= '0;
         left_q  <= '0;
      end else if (cmd_valid) begin
         start_q <= cmd_col;
         mask_q  <= cmd_mask;
         k_q     <= COL_W'(1);
         left_q  <= cmd_left;
         page_q  <= cmd_page;
         wr_q    <= cmd_write;
         act_q   <= cmd_page | (cmd_lg != 2'd0);
      end else if (stop) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         k_q    <= k_q + COL_W'(1);
         left_q <= left_q - LEFT_W'(1);
         if (!page_q && left_q == LEFT_W'(1)) act_q <= 1'b0;
      end
   end

   // R5
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !cmd_valid) |=> (!beat || cmd_valid));

   // R2
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat |=> (!beat || cmd_valid ||
                ((beat_col & mask_q) == (($past(beat_col) + COL_W'(1)) & mask_q))));
endmodule

// File: rtl/sdrb_rdpipe.sv
module sdrb_rdpipe #(
   parameter int MAX_CL = 3,
   localparam int CLW = $clog2(MAX_CL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_beat,
   input  logic           flush,
   input  logic [CLW-1:0] cas_lat,
   output logic           rd_valid,
   output logic           busy
);
   logic [MAX_CL:1] stg;
   logic [CLW-1:0]  tap;

   always_comb begin
      if (cas_lat == '0)                  tap = CLW'(1);
      else if (int'(cas_lat) > MAX_CL)    tap = CLW'(MAX_CL);
      else                                tap = cas_lat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= '0;
      else begin
         stg[1] <= rd_beat & ~flush;
         for (int i = 2; i <= MAX_CL; i++) stg[i] <= stg[i-1] & ~flush;
      end
   end

   generate
      if (MAX_CL == 1) begin : g_single
         assign rd_valid = stg[1] & ~flush;
         assign busy     = stg[1];
      end else begin : g_tapped
         logic busy_c;
         always_comb begin
            busy_c = 1'b0;
            for (int i = 1; i <= MAX_CL; i++)
               if (i <= int'(tap)) busy_c = busy_c | stg[i];
         end
         assign rd_valid = stg[tap] & ~flush;
         assign busy     = busy_c;
      end
   endgenerate

   // R4
   cl1_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_beat && tap == CLW'(1)) |=> (rd_valid || flush || tap != CLW'(1)));
endmodule

// File: rtl/sdr_burst_datapath.sv
module sdr_burst_datapath
   import sdrb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int COL_W  = 9,
   parameter int MAX_CL = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic                         cmd_write,
   input  logic [COL_W-1:0]             cmd_col,
   input  logic                         cmd_stop,
   input  logic [BL_FIELD_W-1:0]        bl_code,
   input  logic [$clog2(MAX_CL+1)-1:0]  cas_lat,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [DATA_W/8-1:0]          wr_be,
   input  logic [DATA_W-1:0]            dq_in,
   output logic                         col_en,
   output logic [COL_W-1:0]             col_out,
   output logic [DATA_W-1:0]            dq_out,
   output logic                         dq_oe,
   output logic [DATA_W/8-1:0]          dqm,
   output logic                         rd_valid,
   output logic [DATA_W-1:0]            rd_data
);
   localparam int BYTES = DATA_W / 8;

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert (COL_W >= 3)      else $error("COL_W must hold an 8-beat block");
      assert (MAX_CL >= 1)     else $error("MAX_CL must be at least 1");
   end

   logic beat, beat_wr, wr_beat, rd_beat, rd_busy;

   sdrb_colgen #(.COL_W(COL_W)) u_colgen (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_col(cmd_col), .stop(cmd_stop), .bl_code(bl_code),
      .beat(beat), .beat_wr(beat_wr), .beat_col(col_out)
   );

   assign wr_beat = beat & beat_wr;
   assign rd_beat = beat & ~beat_wr;

   sdrb_rdpipe #(.MAX_CL(MAX_CL)) u_rdpipe (
      .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .flush(wr_beat),
      .cas_lat(cas_lat), .rd_valid(rd_valid), .busy(rd_busy)
   );

   always_comb begin
      col_en  = beat;
      dq_oe   = wr_beat;
      dq_out  = wr_data;
      rd_data = dq_in;
      if (wr_beat)                dqm = ~wr_be;
      else if (rd_beat | rd_busy) dqm = '0;
      else                        dqm = {BYTES{1'b1}};
   end

   // R8
   bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_valid, dq_oe}));
endmodule

// File: tb/sdr_burst_datapath_bench.sv
`timescale 1ns/100ps
module sdr_burst_datapath_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 0, cmd_write = 0, cmd_stop = 0;
   logic [8:0]  cmd_col = '0;
   logic [2:0]  bl_code = '0;
   logic [1:0]  cas_lat = 2'd1;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] dq_in;
   logic col_en, dq_oe, rd_valid;
   logic [8:0]  col_out;
   logic [31:0] dq_out, rd_data;
   logic [3:0]  dqm;

   always #2.5 clk = ~clk;

   sdr_burst_datapath u_sdr_burst_datapath (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_col(cmd_col), .cmd_stop(cmd_stop), .bl_code(bl_code), .cas_lat(cas_lat),
      .wr_data(wr_data), .wr_be(wr_be), .dq_in(dq_in), .col_en(col_en),
      .col_out(col_out), .dq_out(dq_out), .dq_oe(dq_oe), .dqm(dqm),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // behavioural memory: stores masked writes, returns read words CL cycles later
   logic [31:0] mem [512];
   logic [2:0]  h_rd = '0;
   logic [8:0]  h_col [3];
   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (col_en && dq_oe)
         for (int b = 0; b < 4; b++) if (!dqm[b]) mem[col_out][8*b +: 8] <= dq_out[8*b +: 8];
      h_rd     <= {h_rd[1:0], col_en & ~dq_oe};
      h_col[2] <= h_col[1];
      h_col[1] <= h_col[0];
      h_col[0] <= col_out;
   end
   assign dq_in = h_rd[cas_lat-2'd1] ? mem[h_col[cas_lat-2'd1]] : 32'hBAD0BAD0;

   logic [31:0] rq_d [$];
   int          rq_c [$];
   always @(negedge clk) begin
      #2;
      if (rd_valid) begin rq_d.push_back(rd_data); rq_c.push_back(cyc); end
   end

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic int blen(input logic [2:0] code);
      return code[2] ? 512 : (1 << code[1:0]);
   endfunction
   function automatic logic [8:0] expcol(input logic [8:0] s, input logic [2:0] code, input int k);
      logic [8:0] m;
      m = 9'(blen(code) - 1);
      return (s & ~m) | (9'(int'(s) + k) & m);
   endfunction
   function automatic logic [31:0] wdat(input int v, input int k);
      return {8'(v), 8'(k), 16'hC0DE};
   endfunction

   task automatic drv(input logic cv, input logic wr, input logic [8:0] col, input logic stp,
                      input logic [2:0] bl, input logic [31:0] wd, input logic [3:0] be);
      @(negedge clk);
      cmd_valid = cv; cmd_write = wr; cmd_col = col; cmd_stop = stp;
      bl_code = bl; wr_data = wd; wr_be = be;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drv(0, 0, '0, 0, bl_code, '0, '0);
   endtask

   // {write, bl_code, cas_lat, start column, stop after n beats (0 = none)}
   localparam int NV = 13;
   localparam logic [24:0] VECS [NV] = '{
      {1'b0, 3'd0, 2'd1, 9'd5,   10'd0},
      {1'b0, 3'd1, 2'd2, 9'd7,   10'd0},
      {1'b0, 3'd2, 2'd3, 9'd10,  10'd0},
      {1'b0, 3'd3, 2'd1, 9'd13,  10'd0},
      {1'b0, 3'd7, 2'd2, 9'd510, 10'd4},
      {1'b0, 3'd3, 2'd3, 9'd0,   10'd3},
      {1'b1, 3'd0, 2'd1, 9'd100, 10'd0},
      {1'b1, 3'd1, 2'd3, 9'd201, 10'd0},
      {1'b1, 3'd2, 2'd2, 9'd302, 10'd0},
      {1'b1, 3'd3, 2'd2, 9'd45,  10'd0},
      {1'b1, 3'd7, 2'd3, 9'd509, 10'd5},
      {1'b1, 3'd3, 2'd1, 9'd64,  10'd2},
      {1'b0, 3'd2, 2'd3, 9'd300, 10'd0}
   };

   task automatic check_reads(input string req, input int n, input logic [8:0] cols [],
                              input int t0, input int cl);
      chk({req, " read count"}, rq_d.size(), n);
      for (int j = 0; j < n && j < rq_d.size(); j++) begin
         chk({req, " read data"}, rq_d[j], mem[cols[j]]);
         chk({req, " read cycle"}, rq_c[j], t0 + cl + j);
      end
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = 32'h5A00_0000 | (i << 4) | 32'h3;
      h_col[0] = '0; h_col[1] = '0; h_col[2] = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R10 col_en", col_en, 0);
      chk("R10 dq_oe", dq_oe, 0);
      chk("R10 rd_valid", rd_valid, 0);
      chk("R10 dqm", dqm, 4'hF);
      @(negedge clk); rst_n = 1;
      idle(2);

      for (int v = 0; v < NV; v++) begin
         logic wr; logic [2:0] bl; logic [1:0] cl; logic [8:0] s; int stp, n, t0;
         logic [8:0] cols [];
         logic [31:0] after_val;
         wr = VECS[v][24]; bl = VECS[v][23:21]; cl = VECS[v][20:19];
         s = VECS[v][18:10]; stp = int'(VECS[v][9:0]);
         n = (stp != 0) ? stp : blen(bl);
         cols = new[n];
         for (int k = 0; k < n; k++) cols[k] = expcol(s, bl, k);
         after_val = mem[expcol(s, bl, n)];
         rq_d.delete(); rq_c.delete();
         cas_lat = cl;
         for (int k = 0; k < n; k++) begin
            drv(k == 0, wr, s, 0, bl, wdat(v, k), 4'hF);
            if (k == 0) t0 = cyc;
            #1;
            chk(bl[2] ? "R3 column" : "R2 column", col_out, cols[k]);
            chk("R1 beat", col_en, 1);
            chk("R7 dq_oe", dq_oe, wr);
            chk(wr ? "R7 dqm" : "R9 dqm read", dqm, 4'h0);
            if (wr) chk("R7 dq_out", dq_out, wdat(v, k));
         end
         drv(0, 0, '0, stp != 0, bl, '0, 4'hF);
         #1;
         chk(stp != 0 ? "R5 stopped" : "R1 ended", col_en, 0);
         if (stp != 0 && wr) chk("R5 dqm stop", dqm, 4'hF);
         idle(6);
         #1;
         chk("R9 dqm idle", dqm, 4'hF);
         if (wr) begin
            for (int k = 0; k < n; k++) chk("R7 stored", mem[cols[k]], wdat(v, k));
            if (stp != 0) chk("R5 no write after stop", mem[expcol(s, bl, n)], after_val);
         end else begin
            check_reads(stp != 0 ? "R4 R5" : "R4", n, cols, t0, cl);
         end
      end

      // R6: read BL4 cut by read BL2 after two beats
      begin
         int t0; logic [8:0] cols [] = new[4];
         cols[0] = 0; cols[1] = 1; cols[2] = 20; cols[3] = 21;
         rq_d.delete(); rq_c.delete(); cas_lat = 2;
         drv(1, 0, 9'd0, 0, 3'd2, '0, '0); t0 = cyc;
         drv(0, 0, '0, 0, 3'd2, '0, '0);
         drv(1, 0, 9'd20, 0, 3'd1, '0, '0);
         #1; chk("R6 new column", col_out, 9'd20);
         drv(0, 0, '0, 0, 3'd1, '0, '0);
         #1; chk("R6 second beat", col_out, 9'd21);
         idle(6);
         check_reads("R6", 4, cols, t0, 2);
      end

      // R8: write after two beats of CL1 read BL8
      begin
         int t0; logic [8:0] cols [] = new[1];
         cols[0] = 0;
         rq_d.delete(); rq_c.delete(); cas_lat = 1;
         drv(1, 0, 9'd0, 0, 3'd3, '0, '0); t0 = cyc;
         drv(0, 0, '0, 0, 3'd3, '0, '0);
         drv(1, 1, 9'd400, 0, 3'd0, 32'h0F0F_0F0F, 4'hF);
         #1;
         chk("R8 rd_valid on write", rd_valid, 0);
         chk("R8 dq_oe", dq_oe, 1);
         idle(6);
         check_reads("R8", 1, cols, t0, 1);
      end

      // R7: partial byte mask
      drv(1, 1, 9'd450, 0, 3'd0, 32'h1122_3344, 4'hF);
      drv(1, 1, 9'd450, 0, 3'd0, 32'hAABB_CCDD, 4'b0101);
      #1; chk("R7 dqm mask", dqm, 4'b1010);
      idle(2);
      chk("R7 masked store", mem[450], 32'h11BB_33DD);

      // R11: command and stop together
      begin
         int t0; logic [8:0] cols [] = new[2];
         cols[0] = 30; cols[1] = 31;
         rq_d.delete(); rq_c.delete(); cas_lat = 1;
         drv(1, 0, 9'd30, 1, 3'd1, '0, '0); t0 = cyc;
         drv(0, 0, '0, 0, 3'd1, '0, '0);
         #1; chk("R11 burst continues", col_en, 1);
         idle(5);
         check_reads("R11", 2, cols, t0, 1);
      end

      // R9: mask stays low while read data is in flight
      cas_lat = 3;
      drv(1, 0, 9'd7, 0, 3'd0, '0, '0);
      drv(0, 0, '0, 0, 3'd0, '0, '0);
      #1; chk("R9 dqm pending", dqm, 4'h0);
      idle(3);
      #1; chk("R9 dqm drained", dqm, 4'hF);
      idle(2);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule